// File: doc/BRIEF.md
# Auxiliary Power and System Control Registers

This block is a small bank of memory-mapped control registers for a system controller. A processor reaches it over a plain synchronous bus: a select strobe, a write enable, a small word address, 32-bit write data and combinational read data. It holds three byte-wide scratch and control registers (configuration, diagnostic, modem control), a byte-wide auxiliary register that can fire a terminal-count strobe at a floppy controller, a power-control register with a sticky power-fail flag, a 16-bit LED word and a 32-bit system-control word.

The power-fail input is watched for changes. When it changes, the flag is set if the input is now high and the power-interrupt enable in the configuration register is set. In every other case a change clears the flag. Between changes the flag holds its value until software clears it with a write-one bit. The interrupt line is the flag gated by the enable. Writes to the other control bits request power-off, a system reset or a CPU halt. The block only raises these requests; other logic carries them out. The diagnostic, LED and system-control words are not touched by reset, so software can read them back afterwards, for example to find the reset-status bit.

Top module: `aux_sysctl_regs`

## Requirements
- R1: Slots 0 (configuration), 1 (diagnostic) and 2 (modem control) store bits 7:0 of the write data. A read returns that byte with bits 31:8 zero.
- R2: Slot 3 (LED) stores bits 15:0 of the write data and reads back with bits 31:16 zero. Slot 4 (system control) stores all 32 bits when bit 0 of the write data is 0.
- R3: A write to slot 4 with bit 0 set stores 0x00000002 and drives `sysrst_req_o` high for exactly the one cycle after the write edge.
- R4: A write to slot 5 (auxiliary-1) stores bits 7:0 with bit 0 forced to 0. When bit 0 of the write data is 1, `tc_pulse_o` is high for exactly one cycle after the write edge.
- R5: A write to slot 6 (power control) stores only data bits 1:0. A read of slot 6 returns those two bits in bits 1:0 and the power-fail flag in bit 5, with every other bit 0. `pwroff_req_o` equals stored bit 0.
- R6: A change of `pwr_fail_in` sets the power-fail flag at the next clock edge if the input is now high and configuration bit 3 is 1. Otherwise the change clears the flag. With no change on the input, the flag holds its value, including through slot-6 writes whose bit 1 is 0.
- R7: A slot-6 write with data bit 1 set clears the power-fail flag. This takes priority over an input change in the same cycle.
- R8: `irq_o` is high exactly when the power-fail flag and configuration bit 3 are both 1. Clearing bit 3 masks the interrupt without clearing the flag.
- R9: Any write to slot 7 drives `halt_req_o` high for one cycle. Reads of slot 7 and of slots 8–15 return 0, and writes to slots 8–15 change nothing.
- R10: Reset clears the configuration, modem-control, auxiliary-1 and power-control registers, the power-fail flag and all request outputs. The diagnostic, LED and system-control words keep their values through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register slot number |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, 0 when not reading) |
| pwr_fail_in | input | 1 | Power-fail indication |
| irq_o | output | 1 | Power-fail interrupt |
| pwroff_req_o | output | 1 | Power-off request |
| sysrst_req_o | output | 1 | One-cycle system-reset request |
| tc_pulse_o | output | 1 | One-cycle floppy terminal-count strobe |
| halt_req_o | output | 1 | One-cycle CPU-halt request |

## Verification
The bench holds `pwr_fail_in` high while software clears the flag. A design that re-evaluated the level every cycle instead of on changes would set the flag again and leave the interrupt high. It writes slot 6 without the clear bit while the flag is set. A design that stored the whole write byte would lose the flag or show stray bits. It masks and unmasks the enable. A design that cleared the flag on masking would not bring the interrupt back. It also checks that the diagnostic, LED and system-control words survive reset while the other registers clear, that the system-control word then reads the reset-status value 0x2, and that each request strobe falls after one cycle.

// File: rtl/aux_ctl_pkg.sv
`timescale 1ns/1ps
package aux_ctl_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int LED_W   = 16;
    localparam int CTL2_W  = 2;

    // slot numbers of the local decode
    localparam int SLOT_CFG   = 0;
    localparam int SLOT_DIAG  = 1;
    localparam int SLOT_MDM   = 2;
    localparam int SLOT_LED   = 3;
    localparam int SLOT_SYS   = 4;
    localparam int SLOT_AUX1  = 5;
    localparam int SLOT_AUX2  = 6;
    localparam int SLOT_PM    = 7;
    localparam int SLOT_COUNT = 8;

    // bit positions software depends on
    localparam int CFG_EN_BIT    = 3;
    localparam int AUX2_OFF_BIT  = 0;
    localparam int AUX2_CLR_BIT  = 1;
    localparam int AUX2_FLAG_BIT = 5;
    localparam int AUX1_TC_BIT   = 0;
    localparam int SYS_RST_BIT   = 0;
    localparam logic [WORD_W-1:0] SYS_RST_STATUS = WORD_W'(2);

    typedef struct packed {
        logic [BYTE_W-1:0] cfg;
        logic [BYTE_W-1:0] mdm;
        logic [BYTE_W-1:0] aux1;
        logic [CTL2_W-1:0] aux2_ctl;
        logic              tc;
        logic              sysrst;
        logic              halt;
    } clr_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] diag;
        logic [LED_W-1:0]  led;
        logic [WORD_W-1:0] sysctrl;
    } keep_state_t;

endpackage

// File: rtl/aux_ctl_decode.sv
`timescale 1ns/1ps
module aux_ctl_decode #(
    parameter int ADDR_W = 4,
    parameter int NSLOT  = 8
) (
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NSLOT-1:0]  wr_hit_o,
    output logic [NSLOT-1:0]  rd_hit_o
);

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic match;
        assign match       = (addr_i == ADDR_W'(i));
        assign wr_hit_o[i] = sel_i & we_i & match;
        assign rd_hit_o[i] = sel_i & ~we_i & match;
    end

endmodule

// File: rtl/aux_pf_track.sv
`timescale 1ns/1ps
module aux_pf_track (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_i,
    input  logic en_i,
    input  logic clr_i,
    output logic flag_o
);

    typedef struct packed {
        logic prev;
        logic flag;
    } pf_state_t;

    pf_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pf_i;
        if (pf_i != st_q.prev) begin
            st_d.flag = pf_i & en_i;
        end
        if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/aux_sysctl_regs.sv
`timescale 1ns/1ps
module aux_sysctl_regs
    import aux_ctl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              pwr_fail_in,
    output logic              irq_o,
    output logic              pwroff_req_o,
    output logic              sysrst_req_o,
    output logic              tc_pulse_o,
    output logic              halt_req_o
);

    localparam int NSLOT = SLOT_COUNT;

    clr_state_t  clr_d,  clr_q;
    keep_state_t keep_d, keep_q;

    logic [NSLOT-1:0] wr_hit;
    logic [NSLOT-1:0] rd_hit;
    logic             clr_flag;
    logic             pf_flag;
    logic [BYTE_W-1:0] aux2_view;

    aux_ctl_decode #(
        .ADDR_W (ADDR_W),
        .NSLOT  (NSLOT)
    ) u_dec (
        .sel_i    (bus_sel),
        .we_i     (bus_we),
        .addr_i   (bus_addr),
        .wr_hit_o (wr_hit),
        .rd_hit_o (rd_hit)
    );

    assign clr_flag = wr_hit[SLOT_AUX2] & bus_wdata[AUX2_CLR_BIT];

    aux_pf_track u_pf (
        .clk    (clk),
        .rst_n  (rst_n),
        .pf_i   (pwr_fail_in),
        .en_i   (clr_q.cfg[CFG_EN_BIT]),
        .clr_i  (clr_flag),
        .flag_o (pf_flag)
    );

    // next-state computation for both register groups
    always_comb begin
        clr_d        = clr_q;
        keep_d       = keep_q;
        clr_d.tc     = 1'b0;
        clr_d.sysrst = 1'b0;
        clr_d.halt   = 1'b0;

        if (wr_hit[SLOT_CFG])  clr_d.cfg   = bus_wdata[BYTE_W-1:0];
        if (wr_hit[SLOT_DIAG]) keep_d.diag = bus_wdata[BYTE_W-1:0];
        if (wr_hit[SLOT_MDM])  clr_d.mdm   = bus_wdata[BYTE_W-1:0];
        if (wr_hit[SLOT_LED])  keep_d.led  = bus_wdata[LED_W-1:0];

        if (wr_hit[SLOT_SYS]) begin
            if (bus_wdata[SYS_RST_BIT]) begin
                keep_d.sysctrl = SYS_RST_STATUS;
                clr_d.sysrst   = 1'b1;
            end else begin
                keep_d.sysctrl = bus_wdata;
            end
        end

        if (wr_hit[SLOT_AUX1]) begin
            clr_d.aux1              = bus_wdata[BYTE_W-1:0];
            clr_d.aux1[AUX1_TC_BIT] = 1'b0;
            clr_d.tc                = bus_wdata[AUX1_TC_BIT];
        end

        if (wr_hit[SLOT_AUX2]) clr_d.aux2_ctl = bus_wdata[CTL2_W-1:0];
        if (wr_hit[SLOT_PM])   clr_d.halt     = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_q <= '0;
        end else begin
            clr_q <= clr_d;
        end
    end

    // retained across reset by design
    always_ff @(posedge clk) begin
        keep_q <= keep_d;
    end

    always_comb begin
        aux2_view                = '0;
        aux2_view[CTL2_W-1:0]    = clr_q.aux2_ctl;
        aux2_view[AUX2_FLAG_BIT] = pf_flag;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_hit[SLOT_CFG])  bus_rdata = WORD_W'(clr_q.cfg);
        if (rd_hit[SLOT_DIAG]) bus_rdata = WORD_W'(keep_q.diag);
        if (rd_hit[SLOT_MDM])  bus_rdata = WORD_W'(clr_q.mdm);
        if (rd_hit[SLOT_LED])  bus_rdata = WORD_W'(keep_q.led);
        if (rd_hit[SLOT_SYS])  bus_rdata = keep_q.sysctrl;
        if (rd_hit[SLOT_AUX1]) bus_rdata = WORD_W'(clr_q.aux1);
        if (rd_hit[SLOT_AUX2]) bus_rdata = WORD_W'(aux2_view);
        if (rd_hit[SLOT_PM])   bus_rdata = '0;
    end

    assign irq_o        = pf_flag & clr_q.cfg[CFG_EN_BIT];
    assign pwroff_req_o = clr_q.aux2_ctl[AUX2_OFF_BIT];
    assign sysrst_req_o = clr_q.sysrst;
    assign tc_pulse_o   = clr_q.tc;
    assign halt_req_o   = clr_q.halt;

endmodule

// File: rtl/aux_sysctl_chk.sv
`timescale 1ns/1ps
module aux_sysctl_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq_o,
    input logic              pwroff_req_o,
    input logic              sysrst_req_o,
    input logic              tc_pulse_o,
    input logic              halt_req_o
);

    logic wr_sys, wr_aux1, wr_aux2, wr_cfg, wr_pm, rd_pm;
    assign wr_sys  = bus_sel & bus_we & (bus_addr == ADDR_W'(4));
    assign wr_aux1 = bus_sel & bus_we & (bus_addr == ADDR_W'(5));
    assign wr_aux2 = bus_sel & bus_we & (bus_addr == ADDR_W'(6));
    assign wr_cfg  = bus_sel & bus_we & (bus_addr == ADDR_W'(0));
    assign wr_pm   = bus_sel & bus_we & (bus_addr == ADDR_W'(7));
    assign rd_pm   = bus_sel & ~bus_we & (bus_addr == ADDR_W'(7));

    AST_SYSRST_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sys && bus_wdata[0]) |=> sysrst_req_o); // R3
    AST_SYSRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sysrst_req_o |-> $past(wr_sys && bus_wdata[0])); // R3
    AST_TC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse_o |-> $past(wr_aux1 && bus_wdata[0])); // R4
    AST_PWROFF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_aux2 |=> (pwroff_req_o == $past(bus_wdata[0]))); // R5
    AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_aux2 && bus_wdata[1]) |=> !irq_o); // R7
    AST_MASK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && !bus_wdata[3]) |=> !irq_o); // R8
    AST_HALT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pm |=> halt_req_o); // R9
    AST_PM_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pm |-> (bus_rdata == 32'd0)); // R9

endmodule

bind aux_sysctl_regs aux_sysctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .irq_o        (irq_o),
    .pwroff_req_o (pwroff_req_o),
    .sysrst_req_o (sysrst_req_o),
    .tc_pulse_o   (tc_pulse_o),
    .halt_req_o   (halt_req_o)
);

// File: tb/tb_aux_sysctl_regs.sv
`timescale 1ns/1ps
module tb_aux_sysctl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwr_fail_in = 1'b0;
    logic        irq_o, pwroff_req_o, sysrst_req_o, tc_pulse_o, halt_req_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    aux_sysctl_regs #(.ADDR_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwr_fail_in(pwr_fail_in), .irq_o(irq_o), .pwroff_req_o(pwroff_req_o),
        .sysrst_req_o(sysrst_req_o), .tc_pulse_o(tc_pulse_o), .halt_req_o(halt_req_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic set_pf(input logic v);
        @(negedge clk);
        pwr_fail_in = v;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        chk("R10 irq after reset", 32'(irq_o), 0);
        chk("R10 pwroff after reset", 32'(pwroff_req_o), 0);
        chk("R10 strobes after reset", {29'd0, sysrst_req_o, tc_pulse_o, halt_req_o}, 0);
        rd(0, v); chk("R10 cfg reset", v, 0);
        rd(2, v); chk("R10 mdm reset", v, 0);
        rd(5, v); chk("R10 aux1 reset", v, 0);
        rd(6, v); chk("R10 aux2 reset", v, 0);
    endtask

    task automatic t_byte_regs();
        logic [31:0] v;
        wr(0, 32'h1234_56F0); rd(0, v); chk("R1 cfg low byte", v, 32'hF0);
        wr(1, 32'hDEAD_BE3C); rd(1, v); chk("R1 diag low byte", v, 32'h3C);
        wr(2, 32'h0000_7781); rd(2, v); chk("R1 mdm low byte", v, 32'h81);
        rd(0, v); chk("R1 cfg unchanged by other slots", v, 32'hF0);
    endtask

    task automatic t_wide_regs();
        logic [31:0] v;
        wr(3, 32'hCAFE_1234); rd(3, v); chk("R2 led 16 bits", v, 32'h1234);
        wr(4, 32'h8000_00F0);
        chk("R2 no sysrst for bit0 clear", 32'(sysrst_req_o), 0);
        rd(4, v); chk("R2 sysctrl full word", v, 32'h8000_00F0);
    endtask

    task automatic t_sysrst();
        logic [31:0] v;
        wr(4, 32'hFFFF_FFFF);
        chk("R3 sysrst pulse high", 32'(sysrst_req_o), 1);
        @(negedge clk);
        chk("R3 sysrst pulse one cycle", 32'(sysrst_req_o), 0);
        rd(4, v); chk("R3 sysctrl reset status", v, 32'h2);
    endtask

    task automatic t_aux1();
        logic [31:0] v;
        wr(5, 32'hFF);
        chk("R4 tc pulse high", 32'(tc_pulse_o), 1);
        @(negedge clk);
        chk("R4 tc pulse one cycle", 32'(tc_pulse_o), 0);
        rd(5, v); chk("R4 aux1 bit0 dropped", v, 32'hFE);
        wr(5, 32'h40);
        chk("R4 no tc without bit0", 32'(tc_pulse_o), 0);
        rd(5, v); chk("R4 aux1 store", v, 32'h40);
    endtask

    task automatic t_aux2_mask();
        logic [31:0] v;
        wr(6, 32'hFFFF_FFFF);
        chk("R5 pwroff set", 32'(pwroff_req_o), 1);
        rd(6, v); chk("R5 aux2 keeps bits1:0", v, 32'h03);
        wr(6, 32'h0);
        chk("R5 pwroff clear", 32'(pwroff_req_o), 0);
        rd(6, v); chk("R5 aux2 zero", v, 32'h00);
    endtask

    task automatic t_pwrfail();
        logic [31:0] v;
        wr(0, 32'h08);
        set_pf(1'b1);
        chk("R8 irq on flag and enable", 32'(irq_o), 1);
        rd(6, v); chk("R6 flag set", v, 32'h20);
        wr(6, 32'h01);
        rd(6, v); chk("R6 flag survives write", v, 32'h21);
        chk("R6 irq held", 32'(irq_o), 1);
        chk("R5 pwroff with flag", 32'(pwroff_req_o), 1);
        wr(6, 32'h02);
        chk("R7 clear drops irq", 32'(irq_o), 0);
        repeat (3) @(negedge clk);
        rd(6, v); chk("R7 flag stays clear with input high", v, 32'h02);
        set_pf(1'b0);
        wr(0, 32'h00);
        set_pf(1'b1);
        rd(6, v); chk("R6 enable gates flag", v, 32'h02);
        chk("R8 no irq when disabled", 32'(irq_o), 0);
        set_pf(1'b0);
        wr(0, 32'h08);
        set_pf(1'b1);
        chk("R6 rising sets flag", 32'(irq_o), 1);
        wr(0, 32'h00);
        chk("R8 mask drops irq", 32'(irq_o), 0);
        rd(6, v); chk("R8 mask keeps flag", v, 32'h22);
        wr(0, 32'h08);
        chk("R8 unmask restores irq", 32'(irq_o), 1);
        set_pf(1'b0);
        chk("R6 falling clears flag", 32'(irq_o), 0);
        rd(6, v); chk("R6 flag clear after fall", v, 32'h02);
    endtask

    task automatic t_halt_unmapped();
        logic [31:0] v;
        wr(7, 32'h0);
        chk("R9 halt pulse", 32'(halt_req_o), 1);
        @(negedge clk);
        chk("R9 halt one cycle", 32'(halt_req_o), 0);
        rd(7, v); chk("R9 pm reads zero", v, 0);
        rd(0, v);
        wr(9, 32'hFFFF_FFFF);
        rd(9, v); chk("R9 unmapped reads zero", v, 0);
        rd(0, v); chk("R9 unmapped write ignored", v, 32'h08);
        chk("R9 unmapped write no strobe", {29'd0, sysrst_req_o, tc_pulse_o, halt_req_o}, 0);
    endtask

    task automatic t_reset_keep();
        logic [31:0] v;
        wr(1, 32'h5A); wr(3, 32'hBEEF); wr(4, 32'h1);
        wr(0, 32'h08); wr(2, 32'h33); wr(5, 32'h80); wr(6, 32'h01);
        set_pf(1'b1);
        chk("R10 irq before reset", 32'(irq_o), 1);
        pwr_fail_in = 1'b0;
        do_reset();
        chk("R10 irq cleared", 32'(irq_o), 0);
        chk("R10 pwroff cleared", 32'(pwroff_req_o), 0);
        rd(0, v); chk("R10 cfg cleared", v, 0);
        rd(2, v); chk("R10 mdm cleared", v, 0);
        rd(5, v); chk("R10 aux1 cleared", v, 0);
        rd(6, v); chk("R10 aux2 and flag cleared", v, 0);
        rd(1, v); chk("R10 diag kept", v, 32'h5A);
        rd(3, v); chk("R10 led kept", v, 32'hBEEF);
        rd(4, v); chk("R10 sysctrl kept", v, 32'h2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_byte_regs();
        t_wide_regs();
        t_sysrst();
        t_aux1();
        t_aux2_mask();
        t_pwrfail();
        t_halt_unmapped();
        t_reset_keep();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule